// File: doc/BRIEF.md
# Transmit Descriptor Poll Timer

This block tells a network controller's transmit engine when to scan its descriptor ring again. It holds a programmable interval and a free-running 16-bit up-counter. When the counter passes its top value, the block raises `poll_req` for one clock and reloads the counter from the interval.

The interval is written as a count-up start value. It is the two's complement of the wanted delay, with an implied seventeenth bit of one, so a field value `V` gives a delay of `65536 - V` clocks. The low four bits of the field are not used, which means the delay is always a multiple of 16 clocks and can be as long as 65536 clocks.

Software reaches both registers through a small read/write port. Access works only while the controller is stopped (`halt_i`) or suspended (`pause_i`). While either of those inputs is high, counting is frozen so that a read sees a steady value. Reset clears only the pulse output; both registers keep their contents through it.

Top module: `tdpt_poll_timer`

## Requirements
- R1: When `rst`, `halt_i` and `pause_i` are all low and the counter is below 16'hFFFF, the counter goes up by one on each clock.
- R2: When the counter is 16'hFFFF and the block is running, the next clock loads the counter with the interval field with its bits [3:0] cleared, and raises `poll_req` for exactly that one cycle. The gap between pulses is 65536 minus that cleared value.
- R3: Interval bits [3:0] have no effect. An interval of 16'hFFFF gives the same 16-clock spacing as 16'hFFF0.
- R4: An interval of zero gives a spacing of 65536 clocks.
- R5: While `halt_i` or `pause_i` is high, the counter holds its value unless software writes it.
- R6: A write takes effect only while `halt_i` or `pause_i` is high. `reg_sel` = 0 selects the counter and `reg_sel` = 1 selects the interval. The value is taken from `reg_wdata[15:0]`.
- R7: While both `halt_i` and `pause_i` are low, writes are dropped and `reg_rdata` is zero.
- R8: While access is allowed and `reg_rd` is high, `reg_rdata` returns the selected register in bits [15:0] and zero in bits [31:16]. Write bits [31:16] are ignored. With `reg_rd` low, `reg_rdata` is zero.
- R9: `rst` clears `poll_req` and leaves both the counter and the interval unchanged. Writes made while `rst` is high are ignored.
- R10: `poll_req` is high only in the cycle after a running clock. It is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears only the pulse |
| halt_i | input | 1 | Controller stopped; freezes counting and opens access |
| pause_i | input | 1 | Controller suspended; freezes counting and opens access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read enable |
| reg_sel | input | 1 | 0 = poll counter, 1 = poll interval |
| reg_wdata | input | 32 | Write data; only [15:0] is used |
| reg_rdata | output | 32 | Read data, zero when access is closed |
| poll_req | output | 1 | One-cycle ring poll request |

## Verification
The pulse spacing is measured with four interval patterns:
- The minimum interval, 16'hFFF0, exposes off-by-one errors at reload.
- 16'hFFFF shows whether the low nibble leaks into the reload value.
- 16'h8005 checks that bit 15 is treated as magnitude and not as sign.
- Zero checks the full 65536-clock wrap.

Writes and reads tried while running show whether the access gating works. Writes of values with nonzero upper bits show whether the reserved bits are dropped. A reset pulsed between accesses shows whether the registers hold their contents. A reference model compared on every clock catches any step, freeze or reload error between those points.

// File: rtl/tdpt_pkg.sv
package tdpt_pkg;

    localparam int TDPT_CNT_W   = 16;
    localparam int TDPT_BUS_W   = 32;
    localparam int TDPT_IGN_LSB = 4;

    typedef enum logic {
        SEL_COUNT    = 1'b0,
        SEL_INTERVAL = 1'b1
    } tdpt_sel_e;

    // Reload value: interval with its unused low bits cleared.
    function automatic logic [TDPT_CNT_W-1:0] reload_of(
        input logic [TDPT_CNT_W-1:0] ivl
    );
        logic [TDPT_CNT_W-1:0] r;
        r = ivl;
        r[TDPT_IGN_LSB-1:0] = '0;
        return r;
    endfunction

    function automatic logic [TDPT_BUS_W-1:0] zext(
        input logic [TDPT_CNT_W-1:0] v
    );
        return {{(TDPT_BUS_W-TDPT_CNT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/tdpt_access.sv
module tdpt_access
    import tdpt_pkg::*;
#(
    parameter int CNT_W = TDPT_CNT_W,
    parameter int BUS_W = TDPT_BUS_W
) (
    input  logic             rst,
    input  logic             halt_i,
    input  logic             pause_i,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] ivl_val,
    output logic             ld_cnt,
    output logic             ld_ivl,
    output logic [CNT_W-1:0] ld_data,
    output logic [BUS_W-1:0] reg_rdata
);
    localparam int PAD_W = BUS_W - CNT_W;

    tdpt_sel_e sel;
    logic      open_win;

    always_comb begin
        sel      = tdpt_sel_e'(reg_sel);
        open_win = (halt_i || pause_i) && !rst;
        ld_cnt   = open_win && reg_wr && (sel == SEL_COUNT);
        ld_ivl   = open_win && reg_wr && (sel == SEL_INTERVAL);
        ld_data  = reg_wdata[CNT_W-1:0];
        reg_rdata = '0;
        if (open_win && reg_rd) begin
            reg_rdata = {{PAD_W{1'b0}}, (sel == SEL_INTERVAL) ? ivl_val : cnt_val};
        end
    end

endmodule

// File: rtl/tdpt_interval_reg.sv
module tdpt_interval_reg
    import tdpt_pkg::*;
#(
    parameter int CNT_W   = TDPT_CNT_W,
    parameter int IGN_LSB = TDPT_IGN_LSB
) (
    input  logic             clk,
    input  logic             ld,
    input  logic [CNT_W-1:0] d,
    output logic [CNT_W-1:0] ivl_q,
    output logic [CNT_W-1:0] reload_val
);
    logic [CNT_W-1:0] ivl_r;

    // No reset: the interval survives every reset flavour.
    always_ff @(posedge clk) begin
        if (ld) begin
            ivl_r <= d;
        end
    end

    assign ivl_q      = ivl_r;
    assign reload_val = {ivl_r[CNT_W-1:IGN_LSB], {IGN_LSB{1'b0}}};

endmodule

// File: rtl/tdpt_poll_counter.sv
module tdpt_poll_counter
    import tdpt_pkg::*;
#(
    parameter int CNT_W = TDPT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_data,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             poll_q
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_r;
    logic             poll_r;
    logic             expire;

    assign expire = run && (cnt_r == TOP);

    // Counter holds through reset; only the pulse is cleared.
    always_ff @(posedge clk) begin
        if (ld) begin
            cnt_r <= ld_data;
        end else if (run && !rst) begin
            cnt_r <= expire ? reload_val : cnt_r + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_r <= 1'b0;
        end else begin
            poll_r <= expire;
        end
    end

    assign cnt_q  = cnt_r;
    assign poll_q = poll_r;

endmodule

// File: rtl/tdpt_poll_timer.sv
module tdpt_poll_timer
    import tdpt_pkg::*;
#(
    parameter int CNT_W   = TDPT_CNT_W,
    parameter int BUS_W   = TDPT_BUS_W,
    parameter int IGN_LSB = TDPT_IGN_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_i,
    input  logic             pause_i,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             poll_req
);
    logic             run;
    logic             ld_cnt;
    logic             ld_ivl;
    logic [CNT_W-1:0] ld_data;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ivl_q;
    logic [CNT_W-1:0] reload_val;

    assign run = !halt_i && !pause_i;

    tdpt_access #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_access (
        .rst       (rst),
        .halt_i    (halt_i),
        .pause_i   (pause_i),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .cnt_val   (cnt_q),
        .ivl_val   (ivl_q),
        .ld_cnt    (ld_cnt),
        .ld_ivl    (ld_ivl),
        .ld_data   (ld_data),
        .reg_rdata (reg_rdata)
    );

    tdpt_interval_reg #(.CNT_W(CNT_W), .IGN_LSB(IGN_LSB)) u_ivl (
        .clk        (clk),
        .ld         (ld_ivl),
        .d          (ld_data),
        .ivl_q      (ivl_q),
        .reload_val (reload_val)
    );

    tdpt_poll_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .ld         (ld_cnt),
        .ld_data    (ld_data),
        .reload_val (reload_val),
        .cnt_q      (cnt_q),
        .poll_q     (poll_req)
    );

endmodule

// File: rtl/tdpt_poll_timer_chk.sv
module tdpt_poll_timer_chk #(
    parameter int CNT_W   = 16,
    parameter int BUS_W   = 32,
    parameter int IGN_LSB = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             halt_i,
    input logic             pause_i,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [BUS_W-1:0] reg_rdata,
    input logic             poll_req,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ivl
);
    localparam logic [CNT_W-1:0] TOP = '1;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!halt_i && !pause_i && cnt != TOP) |=> (cnt == CNT_W'($past(cnt) + 1))); // R1

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!halt_i && !pause_i && cnt == TOP) |=>
        (poll_req && cnt[CNT_W-1:IGN_LSB] == $past(ivl[CNT_W-1:IGN_LSB])
         && cnt[IGN_LSB-1:0] == '0)); // R2

    AST_POLL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        poll_req |=> !poll_req); // R10

    AST_POLL_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
        (halt_i || pause_i) |=> !poll_req); // R10

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((halt_i || pause_i) && !(reg_wr && !reg_sel)) |=> $stable(cnt)); // R5

    AST_IVL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!halt_i && !pause_i) |=> $stable(ivl)); // R7

    AST_RD_GATED: assert property (@(posedge clk) disable iff (rst)
        (!halt_i && !pause_i) |-> (reg_rdata == '0)); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[BUS_W-1:CNT_W] == '0); // R8

endmodule

bind tdpt_poll_timer tdpt_poll_timer_chk #(
    .CNT_W(CNT_W), .BUS_W(BUS_W), .IGN_LSB(IGN_LSB)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .halt_i    (halt_i),
    .pause_i   (pause_i),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .poll_req  (poll_req),
    .cnt       (cnt_q),
    .ivl       (ivl_q)
);

// File: tb/tdpt_poll_timer_bench.sv
module tdpt_poll_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt_i = 1'b1;
    logic        pause_i = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        poll_req;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0;
    int m_ivl = 0;
    bit m_poll = 0;

    tdpt_poll_timer u_tdpt_poll_timer (
        .clk(clk), .rst(rst), .halt_i(halt_i), .pause_i(pause_i),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .poll_req(poll_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Model update at each edge, compare a quarter period later.
    always @(posedge clk) begin
        bit acc;
        int exp_rd;
        cycles++;
        acc = halt_i || pause_i;
        if (rst) begin
            m_poll = 0;
        end else if (acc) begin
            m_poll = 0;
            if (reg_wr) begin
                if (reg_sel) m_ivl = int'(reg_wdata[15:0]);
                else         m_cnt = int'(reg_wdata[15:0]);
            end
        end else begin
            if (m_cnt == 65535) begin
                m_cnt  = m_ivl & 16'hFFF0;
                m_poll = 1;
            end else begin
                m_cnt  = m_cnt + 1;
                m_poll = 0;
            end
        end
        #(CLK_PERIOD/4);
        chk("R2/R10 poll_req", poll_req, m_poll);
        exp_rd = 0;
        if ((halt_i || pause_i) && !rst && reg_rd) exp_rd = reg_sel ? m_ivl : m_cnt;
        chk("R1/R5/R7/R8 reg_rdata", reg_rdata, exp_rd);
    end

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_check(input string req, input bit sel, input int exp);
        @(negedge clk);
        reg_rd = 1; reg_sel = sel;
        #1;
        chk(req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 0;
    endtask

    // Configure interval, park counter at top, run, measure pulse gap.
    task automatic spacing(input string req, input logic [15:0] ivl, input int exp_gap);
        int n;
        halt_i = 1; pause_i = 0;
        wr(1, {16'h0, ivl});
        wr(0, 32'h0000_FFFF);
        @(negedge clk);
        halt_i = 0;
        do @(negedge clk); while (!poll_req);
        n = 0;
        do begin @(negedge clk); n++; end while (!poll_req);
        chk(req, n, exp_gap);
        halt_i = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state: no pulse, nothing read
        chk("R9 reset poll_req", poll_req, 0);
        chk("R9 reset rdata", reg_rdata, 0);
        @(negedge clk); rst = 0;

        // R6 R8: writes with garbage in the upper bits, read back
        wr(1, 32'hDEAD_1234);
        wr(0, 32'hBEEF_ABCD);
        rd_check("R6 R8 interval readback", 1, 32'h1234);
        rd_check("R6 R8 counter readback", 0, 32'hABCD);

        // R9: reset keeps values; write during reset ignored
        @(negedge clk); rst = 1;
        reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0000_0011;
        @(negedge clk); reg_wr = 0;
        @(negedge clk); rst = 0;
        rd_check("R9 counter kept", 0, 32'hABCD);
        rd_check("R9 interval kept", 1, 32'h1234);

        // R7: running, writes dropped, reads zero
        @(negedge clk); halt_i = 0;
        reg_rd = 1; reg_sel = 1;
        reg_wr = 1; reg_wdata = 32'h0000_5555;
        #1; chk("R7 read while running", reg_rdata, 0);
        @(negedge clk); reg_sel = 0; reg_wdata = 32'h0000_0007;
        #1; chk("R7 read while running", reg_rdata, 0);
        @(negedge clk); reg_wr = 0; reg_rd = 0;
        repeat (4) @(negedge clk);
        halt_i = 1;
        rd_check("R7 interval unchanged", 1, 32'h1234);
        // R1: ran 6 cycles from ABCD
        rd_check("R1 counter advanced", 0, 32'hABCD + 6);

        // R5: suspend freezes
        @(negedge clk); halt_i = 0; pause_i = 1;
        repeat (5) @(negedge clk);
        rd_check("R5 frozen under suspend", 0, 32'hABCD + 6);
        pause_i = 0; halt_i = 1;

        spacing("R2 min interval gap", 16'hFFF0, 16);
        spacing("R3 low nibble ignored", 16'hFFFF, 16);
        spacing("R2 bit15 magnitude gap", 16'h8005, 32768);
        spacing("R4 zero interval gap", 16'h0000, 65536);

        done = 1;
    end

    initial begin
        wait (done || cycles >= WATCHDOG);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule